// File: doc/BRIEF.md
# Event-Reloaded Watchdog Timer

This block is a host-programmed watchdog. Software stores an 8-bit reload value and picks whether one count unit is one base tick (a second) or sixty base ticks (a minute). A nonzero value starts a countdown at once. When the count runs out, the counter halts at zero and raises a time-out status bit. That bit can drive an interrupt request line. A reload value of zero keeps the timer idle. The reset value is zero, so the timer starts idle.

Three system activity pulses can each be allowed, one by one, to restart the countdown from the stored value and clear the status bit: a keyboard interrupt, a mouse interrupt and a joystick-port access. If none of them is allowed, the time-out cannot be avoided. Software can also force an immediate time-out through a self-clearing bit. It can write the status bit directly at any time.

A three-state machine is at the core. OFF means the reload value is zero and nothing counts. RUN means counting down. DONE means the count is at zero and halted. The transitions are these. LOAD goes from any state to RUN on a nonzero reload write, or on an allowed event when the stored value is nonzero. DISABLE goes from any state to OFF on a zero reload write. EXPIRE goes from RUN to DONE when a unit elapses at count 1. FORCE goes from any state to DONE on the force bit.

Top module: `wdt_event_top`

## Requirements
- R1: After reset, address 0 (reload value) reads 0x00, the status bit is 0 and both interrupt outputs are low.
- R2: While the reload value is 0x00, no number of base ticks changes the status bit, because the timer is disabled.
- R3: Writing a nonzero value N to address 0 loads the count at once. In second mode (address 1 bit 7 = 0) the status bit stays 0 for N-1 ticks and becomes 1 on tick N.
- R4: Once the count reaches zero the counter halts in DONE. Later ticks leave status at 1, and after the host clears status, later ticks do not set it again.
- R5: A write to address 2 sets the status bit to bit 0 of the written data, whatever the counter state is.
- R6: Address 3 bits 0, 1 and 2 enable the keyboard, mouse and joystick events. An enabled event reloads the count from the stored value and clears status. A disabled event has no effect.
- R7: With address 3 bit 3 set, the interrupt level output equals the status bit. The interrupt pulse output is high for exactly the one cycle in which status first reads 1. With bit 3 clear, both outputs stay low.
- R8: Writing address 2 with bit 2 set zeroes the count and sets status. Bit 2 always reads back 0.
- R9: When a forced time-out and an enabled event occur in the same cycle, the forced time-out wins and status is 1.
- R10: In minute mode (address 1 bit 7 = 1) one count unit is 60 base ticks. Every reload restarts this prescaler from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tick_i | input | 1 | One-cycle base tick pulse (one second) |
| kbd_evt_i | input | 1 | Keyboard interrupt event pulse |
| mouse_evt_i | input | 1 | Mouse interrupt event pulse |
| joy_evt_i | input | 1 | Joystick-port access event pulse |
| status_o | output | 1 | Time-out status bit |
| irq_o | output | 1 | Interrupt level, follows status when routed |
| irq_pulse_o | output | 1 | One-cycle pulse on status rising edge when routed |

## Verification
A wrong count or a wrong state shows up at the status bit. The error appears on the exact tick where the time-out should or should not happen, so every expiry is sampled on the tick before it and on the tick at which it occurs. A prescaler that is not cleared on reload shifts a minute-mode expiry by up to 59 ticks, and this is seen on the tick count after a mid-unit event. A priority error between force and event shows at status in the cycle after they coincide. A counter that wraps instead of halting shows as a spurious second expiry after status has been cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W = 8;
    localparam int TICKS_PER_MINUTE = 60;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_DONE = 2'd2
    } wd_state_e;

    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_UNIT   = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_EVCFG  = 2'd3;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int TICKS_PER_UNIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic minutes_i,
    input  logic tick_i,
    output logic unit_tick_o
);
    localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

    logic [PW-1:0] pre_q;

    assign unit_tick_o = tick_i && (!minutes_i || pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_q <= '0;
        else if (clear_i || !minutes_i) pre_q <= '0;
        else if (tick_i)              pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end

    // R10: the prescaler never runs past its last value
    assert_pre_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_val_i,
    input  logic         reload_wr_i,
    input  logic [W-1:0] wr_val_i,
    input  logic         force_i,
    input  logic         stat_wr_i,
    input  logic         stat_wdata_i,
    input  logic         event_i,
    input  logic         unit_tick_i,
    output logic         load_o,
    output logic         status_o
);
    wd_state_e    st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         status_q, status_d;
    logic         expire;

    // next-state and count process
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        load_o = 1'b0;
        expire = 1'b0;
        if (force_i) begin
            cnt_d = '0;
            st_d  = WD_DONE;
        end else if (reload_wr_i) begin
            if (wr_val_i != '0) begin
                cnt_d  = wr_val_i;
                st_d   = WD_RUN;
                load_o = 1'b1;
            end else begin
                cnt_d = '0;
                st_d  = WD_OFF;
            end
        end else if (event_i && reload_val_i != '0) begin
            cnt_d  = reload_val_i;
            st_d   = WD_RUN;
            load_o = 1'b1;
        end else begin
            unique case (st_q)
                WD_OFF:  st_d = WD_OFF;
                WD_RUN: begin
                    if (unit_tick_i) begin
                        if (cnt_q == W'(1)) begin
                            cnt_d  = '0;
                            st_d   = WD_DONE;
                            expire = 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                WD_DONE: st_d = WD_DONE;
                default: st_d = WD_OFF;
            endcase
        end
    end

    // status output process
    always_comb begin
        if (force_i)        status_d = 1'b1;
        else if (stat_wr_i) status_d = stat_wdata_i;
        else if (event_i)   status_d = 1'b0;
        else if (expire)    status_d = 1'b1;
        else                status_d = status_q;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= WD_OFF;
            cnt_q    <= '0;
            status_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    assert_reload_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr_i && !force_i && wr_val_i != '0) |=> (st_q == WD_RUN && cnt_q == $past(wr_val_i)));

    assert_halt_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_RUN && cnt_q == W'(1) && unit_tick_i && !force_i && !reload_wr_i
         && !event_i && !stat_wr_i) |=> (st_q == WD_DONE && status_q));

    assert_stays_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_DONE && !force_i && !reload_wr_i && !event_i) |=> (st_q == WD_DONE && cnt_q == '0));

    assert_event_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !force_i && !stat_wr_i) |=> !status_q);

    assert_force_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (status_q && st_q == WD_DONE && cnt_q == '0));

    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_OFF) |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_event_top.sv
module wdt_event_top
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       tick_i,
    input  logic       kbd_evt_i,
    input  logic       mouse_evt_i,
    input  logic       joy_evt_i,
    output logic       status_o,
    output logic       irq_o,
    output logic       irq_pulse_o
);
    logic [CNT_W-1:0] reload_q;
    logic             minutes_q;
    logic [3:0]       evcfg_q;
    logic             status, status_d1, load, unit_tick, event_hit;
    logic             reload_wr, ctrl_wr, force_to;
    logic [2:0]       ev_vec;

    assign reload_wr = wr_en && wr_addr == A_RELOAD;
    assign ctrl_wr   = wr_en && wr_addr == A_CTRL;
    assign force_to  = ctrl_wr && wr_data[2];

    assign ev_vec = {joy_evt_i, mouse_evt_i, kbd_evt_i};
    always_comb begin
        event_hit = 1'b0;
        for (int i = 0; i < 3; i++) event_hit = event_hit | (ev_vec[i] & evcfg_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q  <= '0;
            minutes_q <= 1'b0;
            evcfg_q   <= '0;
            status_d1 <= 1'b0;
        end else begin
            if (reload_wr)                      reload_q  <= wr_data;
            if (wr_en && wr_addr == A_UNIT)     minutes_q <= wr_data[7];
            if (wr_en && wr_addr == A_EVCFG)    evcfg_q   <= wr_data[3:0];
            status_d1 <= status;
        end
    end

    wdt_prescale #(.TICKS_PER_UNIT(TICKS_PER_MINUTE)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear_i(load), .minutes_i(minutes_q),
        .tick_i(tick_i), .unit_tick_o(unit_tick)
    );

    wdt_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .reload_val_i(reload_q), .reload_wr_i(reload_wr),
        .wr_val_i(wr_data), .force_i(force_to), .stat_wr_i(ctrl_wr),
        .stat_wdata_i(wr_data[0]), .event_i(event_hit), .unit_tick_i(unit_tick),
        .load_o(load), .status_o(status)
    );

    always_comb begin
        unique case (rd_addr)
            A_RELOAD: rd_data = reload_q;
            A_UNIT:   rd_data = {minutes_q, 7'b0};
            A_CTRL:   rd_data = {7'b0, status};
            A_EVCFG:  rd_data = {4'b0, evcfg_q};
            default:  rd_data = '0;
        endcase
    end

    assign status_o    = status;
    assign irq_o       = evcfg_q[3] && status;
    assign irq_pulse_o = evcfg_q[3] && status && !status_d1;

    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse_o |=> !irq_pulse_o);

    assert_force_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_to |=> status_o);
endmodule

// File: tb/tb_wdt_event_top.sv
module tb_wdt_event_top;
    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick_i = 1'b0, kbd_evt_i = 1'b0, mouse_evt_i = 1'b0, joy_evt_i = 1'b0;
    logic       status_o, irq_o, irq_pulse_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  addr;
        logic [10:0] exp;
        logic [10:0] mask;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    wdt_event_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_i(tick_i), .kbd_evt_i(kbd_evt_i),
        .mouse_evt_i(mouse_evt_i), .joy_evt_i(joy_evt_i), .status_o(status_o),
        .irq_o(irq_o), .irq_pulse_o(irq_pulse_o)
    );

    // monitor: pops expected items at the falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [10:0] obs;
                it = sb_q.pop_front();
                rd_addr = it.addr;
                #1;
                obs = {irq_pulse_o, irq_o, status_o, rd_data};
                checks++;
                if ((obs & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, obs & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask

    task automatic push(logic [1:0] a, logic [10:0] e, logic [10:0] m, string tag);
        item_t it;
        it.addr = a; it.exp = e; it.mask = m; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_rd(logic [1:0] a, logic [7:0] v, string tag);
        push(a, {3'b0, v}, 11'h0FF, tag);
    endtask

    task automatic chk_st(logic st, logic irq, string tag);
        push(2'd0, {1'b0, irq, st, 8'h0}, 11'h300, tag);
    endtask

    task automatic chk_pulse(logic p, string tag);
        push(2'd0, {p, 10'h0}, 11'h400, tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; cyc(); tick_i = 1'b0;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk_rd(2'd0, 8'h00, "R1 reload default");
        chk_st(1'b0, 1'b0, "R1 status default");
        chk_pulse(1'b0, "R1 pulse default");
        ticks(5);
        chk_st(1'b0, 1'b0, "R2 disabled no timeout");

        wr(2'd3, 8'h0F);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd3);
        chk_rd(2'd0, 8'd3, "R3 reload readback");
        ticks(2);
        chk_st(1'b0, 1'b0, "R3 before expiry");
        ticks(1);
        chk_st(1'b1, 1'b1, "R3 expiry on tick N");
        chk_pulse(1'b1, "R7 pulse on rise");
        cyc();
        chk_pulse(1'b0, "R7 pulse one cycle");
        ticks(4);
        chk_st(1'b1, 1'b1, "R4 halted status held");
        wr(2'd2, 8'h00);
        chk_st(1'b0, 1'b0, "R5 host clear");
        ticks(10);
        chk_st(1'b0, 1'b0, "R4 no re-expiry after halt");

        wr(2'd0, 8'd3);
        ticks(2);
        kbd_evt_i = 1'b1; cyc(); kbd_evt_i = 1'b0;
        ticks(2);
        chk_st(1'b0, 1'b0, "R6 kbd event reloaded");
        ticks(1);
        chk_st(1'b1, 1'b1, "R6 expiry after reload");
        mouse_evt_i = 1'b1; cyc(); mouse_evt_i = 1'b0;
        chk_st(1'b0, 1'b0, "R6 mouse event clears");
        wr(2'd3, 8'h0B);
        ticks(3);
        chk_st(1'b1, 1'b1, "R6 expiry before joy");
        joy_evt_i = 1'b1; cyc(); joy_evt_i = 1'b0;
        chk_st(1'b1, 1'b1, "R6 disabled joy ignored");

        wr(2'd0, 8'd5);
        wr(2'd2, 8'h00);
        chk_st(1'b0, 1'b0, "R5 clear while counting");
        wr(2'd2, 8'h01);
        chk_st(1'b1, 1'b1, "R5 host set while counting");
        ticks(2);
        chk_st(1'b1, 1'b1, "R5 set held");

        wr(2'd0, 8'd5);
        wr(2'd2, 8'h00);
        ticks(1);
        wr(2'd2, 8'h04);
        chk_st(1'b1, 1'b1, "R8 force sets status");
        chk_rd(2'd2, 8'h01, "R8 force bit reads 0");

        wr(2'd0, 8'd5);
        wr(2'd2, 8'h00);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h04; kbd_evt_i = 1'b1;
        cyc();
        wr_en = 1'b0; kbd_evt_i = 1'b0;
        chk_st(1'b1, 1'b1, "R9 force beats event");
        ticks(6);
        chk_st(1'b1, 1'b1, "R9 stays timed out");

        wr(2'd1, 8'h80);
        chk_rd(2'd1, 8'h80, "R10 unit readback");
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd1);
        ticks(59);
        chk_st(1'b0, 1'b0, "R10 tick 59 no expiry");
        ticks(1);
        chk_st(1'b1, 1'b1, "R10 tick 60 expiry");
        wr(2'd0, 8'd2);
        ticks(30);
        kbd_evt_i = 1'b1; cyc(); kbd_evt_i = 1'b0;
        ticks(119);
        chk_st(1'b0, 1'b0, "R10 prescaler restarted");
        ticks(1);
        chk_st(1'b1, 1'b1, "R10 expiry after 120");

        wr(2'd3, 8'h03);
        chk_st(1'b1, 1'b0, "R7 unrouted irq low");
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        ticks(8);
        chk_st(1'b0, 1'b0, "R2 zero reload disables");
        chk_rd(2'd0, 8'h00, "R2 reload zero readback");

        cyc(); cyc();
        done = 1'b1;
        summary();
    end
endmodule